// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and turns them into two request lines for a processor: a normal request and a fast request. Every source carries an enable bit, a routing bit that picks the normal or the fast path, a software force bit and a 4-bit priority. Pending sources on the normal path are ranked by priority, and a global threshold can hide the low-priority ones. Software reads a vector word to learn which source won, services it, and reads the word again until it returns the empty marker.

All configuration and status goes through a plain 32-bit register bus with word-aligned byte offsets. A write takes effect at the clock edge that samples `bus_wr`. Reads are combinational from `bus_addr`. The bus has no handshake and no back-pressure: the block accepts every write in a single cycle and never stalls. Per-source bit vectors are split across a low word, which holds sources 0 to 31 at bit = source number, and a high word, which holds sources 32 to 63 at bit = source number − 32.

Top module: `prio_intc`

## Requirements
- R1: After reset the following values hold: control 0, enables 0, routing 0, force 0, all priorities 0, threshold 0x1F. The normal vector reads 0xFFFF0000, the fast vector reads 0xFFFF0000, and both request outputs are low.
- R2: The writable words read back what was written. These are control (0x00, 32 bits), threshold (0x04, bits 4:0), enable high/low (0x10/0x14), routing high/low (0x18/0x1C) and force high/low (0x50/0x54). An unmapped or unaligned offset reads as zero, and a write to it changes no state.
- R3: The priority of source s = 8g+k sits in the word at offset 0x20 + 4*(7-g), in bits 4k+3..4k. Group 7 therefore has the lowest address (0x20) and group 0 the highest (0x3C).
- R4: A write of n to 0x08 sets the enable of source n = wdata[5:0]. A write of n to 0x0C clears it. Other enables are unchanged, and both offsets read as zero.
- R5: The request of a source is its input OR its force bit. Normal pending (0x58 high, 0x5C low) is request AND enable AND NOT routing. Fast pending (0x60 high, 0x64 low) is request AND enable AND routing, so a routing bit of 1 selects the fast path.
- R6: The normal vector word at 0x40 returns the winning source number in bits 31:16 and its priority, zero-extended, in bits 15:0. The winner is the pending normal source with the largest priority, and a tie goes to the higher source number. With no winner the word is 0xFFFF0000.
- R7: A normal source can win only if its priority is greater than the threshold at 0x04. A threshold of 16 or more (bit 4 set) turns masking off.
- R8: `irq_norm_o` is high exactly while the normal vector field is not 0xFFFF. `irq_fast_o` is high exactly while any fast pending bit is set. Both follow input and register changes without any added cycle of delay.
- R9: The fast vector word at 0x44 returns the highest-numbered fast pending source in bits 31:16 and zero in bits 15:0. With none pending it returns 0xFFFF0000.
- R10: Offsets 0x48 (high) and 0x4C (low) return the raw source inputs, without enable, force or routing applied.
- R11: Pending state is level-based and is not stored. Clearing an enable, or dropping the input while the force bit is clear, removes the source from pending, the vectors and the requests in the cycle after the write, or at once for an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 64 | Level interrupt inputs, bit n = source n |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
A corrupted enable, routing, force or priority bit shows up at the ports once the affected source is requested. The vector word then names the wrong source, or the wrong priority, and a request line rises or falls wrongly. This appears in the first read after the write that caused it. Because all status is combinational from stored configuration and the live inputs, no fault can stay hidden for several cycles. A wrong result in ranking, tie-break or threshold changes the vector at once, so each random step compares both vectors, both request lines and one randomly chosen register against a bench model.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NSRC   = 64;
  localparam int HALF   = NSRC / 2;
  localparam int PRIO_W = 4;
  localparam int THR_W  = PRIO_W + 1;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int VEC_W  = DATA_W / 2;
  localparam int NGRP   = NSRC * PRIO_W / DATA_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_THR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ENNUM  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DISNUM = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ENH    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ENL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RTH    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RTL    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_NVEC   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FVEC   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_SRCH   = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_SRCL   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_FRCH   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_FRCL   = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_NPH    = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_NPL    = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_FPH    = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_FPL    = 8'h64;

  localparam logic [VEC_W-1:0]  NO_VEC     = '1;
  localparam logic [THR_W-1:0]  THR_RESET  = 5'h1F;

  // priority word: lowest address holds the highest group
  function automatic logic is_prio_ofs(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:5] == 3'b001) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [2:0] prio_grp(input logic [ADDR_W-1:0] a);
    return 3'd7 - a[4:2];
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        ctrl_q,
  output logic [THR_W-1:0]         thr_q,
  output logic [NSRC-1:0]          en_q,
  output logic [NSRC-1:0]          route_q,
  output logic [NSRC-1:0]          force_q,
  output logic [NSRC*PRIO_W-1:0]   prio_q
);
  logic [IDX_W-1:0] num;
  assign num = wdata[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      thr_q   <= THR_RESET;
      en_q    <= '0;
      route_q <= '0;
      force_q <= '0;
      prio_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL:   ctrl_q  <= wdata;
        OFS_THR:    thr_q   <= wdata[THR_W-1:0];
        OFS_ENNUM:  en_q[num] <= 1'b1;
        OFS_DISNUM: en_q[num] <= 1'b0;
        OFS_ENH:    en_q[NSRC-1:HALF]    <= wdata[HALF-1:0];
        OFS_ENL:    en_q[HALF-1:0]       <= wdata[HALF-1:0];
        OFS_RTH:    route_q[NSRC-1:HALF] <= wdata[HALF-1:0];
        OFS_RTL:    route_q[HALF-1:0]    <= wdata[HALF-1:0];
        OFS_FRCH:   force_q[NSRC-1:HALF] <= wdata[HALF-1:0];
        OFS_FRCL:   force_q[HALF-1:0]    <= wdata[HALF-1:0];
        default: begin
          if (is_prio_ofs(addr))
            prio_q[prio_grp(addr)*DATA_W +: DATA_W] <= wdata;
        end
      endcase
    end
  end

  // R4
  ennum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ENNUM) |=> en_q[$past(num)]);

  // R4
  disnum_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DISNUM) |=> !en_q[$past(num)]);

  // R2
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= 8'h68) |=> ($stable(en_q) && $stable(prio_q) &&
                                  $stable(ctrl_q) && $stable(force_q)));
endmodule

// File: rtl/prio_intc_pick.sv
module prio_intc_pick
  import prio_intc_pkg::*;
#(
  parameter bit USE_PRIO = 1'b1
)(
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] prio,
  input  logic [THR_W-1:0]       thr,
  output logic                   found,
  output logic [IDX_W-1:0]       win,
  output logic [PRIO_W-1:0]      win_prio
);
  generate
    if (USE_PRIO) begin : g_ranked
      always_comb begin
        found    = 1'b0;
        win      = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
          logic [PRIO_W-1:0] p;
          p = prio[i*PRIO_W +: PRIO_W];
          if (req[i] && (thr[THR_W-1] || p > thr[PRIO_W-1:0]) &&
              (!found || p >= win_prio)) begin
            found    = 1'b1;
            win      = IDX_W'(i);
            win_prio = p;
          end
        end
      end
    end else begin : g_highest
      always_comb begin
        found    = 1'b0;
        win      = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
          if (req[i]) begin
            found = 1'b1;
            win   = IDX_W'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_i,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  logic [DATA_W-1:0]        ctrl_q;
  logic [THR_W-1:0]         thr_q;
  logic [NSRC-1:0]          en_q, route_q, force_q;
  logic [NSRC*PRIO_W-1:0]   prio_q;
  logic [NSRC-1:0]          req, norm_pend, fast_pend;
  logic                     n_found, f_found;
  logic [IDX_W-1:0]         n_win, f_win;
  logic [PRIO_W-1:0]        n_prio, f_prio;
  logic [DATA_W-1:0]        nvec_word, fvec_word;

  prio_intc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .thr_q(thr_q), .en_q(en_q),
    .route_q(route_q), .force_q(force_q), .prio_q(prio_q)
  );

  assign req       = (src_i | force_q) & en_q;
  assign norm_pend = req & ~route_q;
  assign fast_pend = req & route_q;

  prio_intc_pick #(.USE_PRIO(1'b1)) u_norm_pick (
    .req(norm_pend), .prio(prio_q), .thr(thr_q),
    .found(n_found), .win(n_win), .win_prio(n_prio)
  );

  prio_intc_pick #(.USE_PRIO(1'b0)) u_fast_pick (
    .req(fast_pend), .prio(prio_q), .thr(THR_RESET),
    .found(f_found), .win(f_win), .win_prio(f_prio)
  );

  assign nvec_word = n_found ? {VEC_W'(n_win), VEC_W'(n_prio)} : {NO_VEC, VEC_W'(0)};
  assign fvec_word = f_found ? {VEC_W'(f_win), VEC_W'(0)}      : {NO_VEC, VEC_W'(0)};

  assign irq_norm_o = (nvec_word[DATA_W-1:VEC_W] != NO_VEC);
  assign irq_fast_o = |fast_pend;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_THR:  bus_rdata = DATA_W'(thr_q);
      OFS_ENH:  bus_rdata = en_q[NSRC-1:HALF];
      OFS_ENL:  bus_rdata = en_q[HALF-1:0];
      OFS_RTH:  bus_rdata = route_q[NSRC-1:HALF];
      OFS_RTL:  bus_rdata = route_q[HALF-1:0];
      OFS_NVEC: bus_rdata = nvec_word;
      OFS_FVEC: bus_rdata = fvec_word;
      OFS_SRCH: bus_rdata = src_i[NSRC-1:HALF];
      OFS_SRCL: bus_rdata = src_i[HALF-1:0];
      OFS_FRCH: bus_rdata = force_q[NSRC-1:HALF];
      OFS_FRCL: bus_rdata = force_q[HALF-1:0];
      OFS_NPH:  bus_rdata = norm_pend[NSRC-1:HALF];
      OFS_NPL:  bus_rdata = norm_pend[HALF-1:0];
      OFS_FPH:  bus_rdata = fast_pend[NSRC-1:HALF];
      OFS_FPL:  bus_rdata = fast_pend[HALF-1:0];
      default: begin
        if (is_prio_ofs(bus_addr))
          bus_rdata = prio_q[prio_grp(bus_addr)*DATA_W +: DATA_W];
      end
    endcase
  end

  // R6
  nwin_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_found |-> (norm_pend[n_win] && !route_q[n_win]));

  // R7
  nwin_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_found |-> (thr_q[THR_W-1] || n_prio > thr_q[PRIO_W-1:0]));

  // R8
  irq_norm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> (|norm_pend));

  // R9
  fwin_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast_o |-> (f_found && fast_pend[f_win] && f_prio == '0));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_i = '0;
  logic        irq_norm_o, irq_fast_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [63:0] m_en = '0, m_rt = '0, m_fr = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_thr = 5'h1F;
  logic [31:0] m_ctrl = '0;

  always #4 clk = ~clk;

  prio_intc dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] m_req();
    return (src_i | m_fr) & m_en;
  endfunction

  function automatic logic [31:0] exp_nvec();
    logic [63:0] np = m_req() & ~m_rt;
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (np[i] && (m_thr[4] || m_pr[i] > m_thr[3:0]))
        if (best < 0 || m_pr[i] >= m_pr[best]) best = i;
    if (best < 0) return 32'hFFFF0000;
    return {16'(best), 12'h0, m_pr[best]};
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] fp = m_req() & m_rt;
    for (int i = 63; i >= 0; i--)
      if (fp[i]) return {16'(i), 16'h0};
    return 32'hFFFF0000;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [63:0] np = m_req() & ~m_rt;
    logic [63:0] fp = m_req() & m_rt;
    logic [31:0] w = '0;
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {27'h0, m_thr};
      8'h10: return m_en[63:32];
      8'h14: return m_en[31:0];
      8'h18: return m_rt[63:32];
      8'h1C: return m_rt[31:0];
      8'h40: return exp_nvec();
      8'h44: return exp_fvec();
      8'h48: return src_i[63:32];
      8'h4C: return src_i[31:0];
      8'h50: return m_fr[63:32];
      8'h54: return m_fr[31:0];
      8'h58: return np[63:32];
      8'h5C: return np[31:0];
      8'h60: return fp[63:32];
      8'h64: return fp[31:0];
      default: begin
        if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
          int g = 7 - int'(a[4:2]);
          for (int k = 0; k < 8; k++) w[4*k +: 4] = m_pr[8*g + k];
        end
        return w;
      end
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    case (a)
      8'h00: m_ctrl = d;
      8'h04: m_thr = d[4:0];
      8'h08: m_en[d[5:0]] = 1'b1;
      8'h0C: m_en[d[5:0]] = 1'b0;
      8'h10: m_en[63:32] = d;
      8'h14: m_en[31:0] = d;
      8'h18: m_rt[63:32] = d;
      8'h1C: m_rt[31:0] = d;
      8'h50: m_fr[63:32] = d;
      8'h54: m_fr[31:0] = d;
      default: begin
        if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) begin
          int g = 7 - int'(a[4:2]);
          for (int k = 0; k < 8; k++) m_pr[8*g + k] = d[4*k +: 4];
        end
      end
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic irq_chk(input string tag);
    logic [63:0] fp = m_req() & m_rt;
    chk({tag, " irq_norm"}, 32'(irq_norm_o), 32'(exp_nvec() != 32'hFFFF0000));
    chk({tag, " irq_fast"}, 32'(irq_fast_o), 32'(|fp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rchk("R1 ctrl", 8'h00, 32'h0);
    rchk("R1 thr", 8'h04, 32'h1F);
    rchk("R1 enl", 8'h14, 32'h0);
    rchk("R1 rth", 8'h18, 32'h0);
    rchk("R1 prio g7", 8'h20, 32'h0);
    rchk("R1 nvec", 8'h40, 32'hFFFF0000);
    rchk("R1 fvec", 8'h44, 32'hFFFF0000);
    chk("R1 irqs", {30'h0, irq_norm_o, irq_fast_o}, 32'h0);

    // R2 readback and unmapped offsets
    wr(8'h14, 32'hA5A50001);
    rchk("R2 enl", 8'h14, 32'hA5A50001);
    wr(8'h00, 32'hDEADBEEF);
    rchk("R2 ctrl", 8'h00, 32'hDEADBEEF);
    wr(8'h68, 32'hFFFFFFFF);
    wr(8'h15, 32'hFFFFFFFF);
    rchk("R2 unmapped read", 8'h68, 32'h0);
    rchk("R2 unaligned read", 8'h15, 32'h0);
    rchk("R2 enl after unmapped", 8'h14, 32'hA5A50001);
    rchk("R2 ctrl after unmapped", 8'h00, 32'hDEADBEEF);
    wr(8'h14, 32'h0);

    // R4 enable/disable by number
    wr(8'h08, 32'h28);
    rchk("R4 set 40", 8'h10, 32'h00000100);
    rchk("R4 ennum reads 0", 8'h08, 32'h0);
    wr(8'h0C, 32'hC0000028);
    rchk("R4 clr 40", 8'h10, 32'h0);
    rchk("R4 disnum reads 0", 8'h0C, 32'h0);

    // R3 priority layout, R6 ranking
    wr(8'h20, 32'h20000000);   // source 63 priority 2
    wr(8'h3C, 32'h00300000);   // source 5 priority 3
    rchk("R3 g0 readback", 8'h3C, 32'h00300000);
    wr(8'h08, 32'd63);
    wr(8'h08, 32'd5);
    src_i[63] = 1'b1; src_i[5] = 1'b1;
    rchk("R6 higher prio wins", 8'h40, 32'h00050003);
    irq_chk("R8 active");
    wr(8'h20, 32'h30000000);   // tie at 3
    rchk("R6 tie to higher number", 8'h40, 32'h003F0003);

    // R7 threshold
    wr(8'h04, 32'h3);
    rchk("R7 at threshold masked", 8'h40, 32'hFFFF0000);
    chk("R8 irq_norm low when masked", 32'(irq_norm_o), 32'h0);
    wr(8'h04, 32'h2);
    rchk("R7 above threshold", 8'h40, 32'h003F0003);
    wr(8'h04, 32'h10);
    rchk("R7 bit4 disables", 8'h40, 32'h003F0003);

    // R11 level behaviour
    wr(8'h0C, 32'd63);
    rchk("R11 disable removes", 8'h40, 32'h00050003);
    src_i[5] = 1'b0;
    rchk("R11 input drop", 8'h40, 32'hFFFF0000);
    irq_chk("R11 idle");

    // R5 / R9 fast path
    src_i[5] = 1'b1;
    wr(8'h1C, 32'h20);
    rchk("R9 fast vector", 8'h44, 32'h00050000);
    rchk("R5 fast pending", 8'h64, 32'h20);
    rchk("R5 normal pending empty", 8'h5C, 32'h0);
    chk("R8 irq_fast", 32'(irq_fast_o), 32'h1);

    // R5 force, R10 raw source
    src_i = '0;
    wr(8'h08, 32'd7);
    wr(8'h54, 32'h80);
    rchk("R5 force pending", 8'h5C, 32'h80);
    src_i[40] = 1'b1;
    rchk("R10 source high", 8'h48, 32'h00000100);
    rchk("R10 source low", 8'h4C, 32'h0);

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [7:0] a;
      logic [31:0] dd;
      a  = 8'($urandom_range(0, 27)) << 2;
      dd = $urandom;
      if (a == 8'h04) dd = $urandom_range(0, 31);
      if (a == 8'h10 || a == 8'h14 || a == 8'h50 || a == 8'h54) dd = dd & $urandom;
      wr(a, dd);
      if ($urandom_range(0, 3) == 0) src_i = {$urandom, $urandom} & {$urandom, $urandom};
      rchk("R6 random nvec", 8'h40, exp_nvec());
      rchk("R9 random fvec", 8'h44, exp_fvec());
      irq_chk("R8 random");
      a = 8'($urandom_range(0, 27)) << 2;
      rd(a, d);
      chk($sformatf("R2 R5 random read %h", a), d, exp_read(a));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule